// File: doc/BRIEF.md
# USB Endpoint Interrupt Request Register

This block holds the interrupt request state for a small group of USB device endpoints. The group has four endpoints of different kinds: a bulk IN endpoint, a bulk OUT endpoint, an isochronous IN endpoint and an isochronous OUT endpoint. Each endpoint has one request bit and one mask bit. A request bit sets while its mask bit is 0 and any of that endpoint's event flags is high. Software clears a request bit by writing 1 to it.

The block also captures the frame number carried by each start-of-frame (SOF) packet. It keeps an isochronous OUT error flag and a SOF status/mask pair. From all this state it drives one registered interrupt line. Software reaches the state through a simple write strobe and address, and reads it back on a combinational read bus.

The address map is as follows. Address 0 holds the request bits. Address 1 holds the endpoint masks. Address 2 holds the low frame bits. Address 3 holds a frame-high/status word.

Top module: `usb_ep_irq_regs`

## Requirements
- R1: After reset the request bits, the isochronous error flag, the SOF status and the interrupt output are 0, and all mask bits are 1. Address 1 reads 0x0F and address 3 reads 0x20.
- R2: Mask bit n is bit n of address 1 (read/write), and it masks request bit n. Request bit 0 (bulk IN) sets one clock after a cycle in which mask bit 0 is 0 and the IN-done flag is 1. It never sets while mask bit 0 is 1.
- R3: Request bit 1 (bulk OUT) sets one clock after a cycle in which mask bit 1 is 0 and the OUT-ready flag is 1.
- R4: Request bit 2 (isochronous IN) sets one clock after a cycle in which mask bit 2 is 0 and either IN-done or transmit underrun is 1.
- R5: Request bit 3 (isochronous OUT) sets one clock after a cycle in which mask bit 3 is 0 and any of OUT-ready, receive overflow or the stored isochronous error flag is 1.
- R6: The request bits are bits 3:0 of address 0. Writing 1 to a bit clears it and writing 0 leaves it unchanged. When a set condition and a clearing write fall in the same cycle, the bit stays set.
- R7: The isochronous error flag is bit 3 of address 3. An error strobe sets it and writing 1 to that bit clears it. A set in the same cycle as the clear wins.
- R8: On a SOF strobe the 11-bit frame number is latched. Its low 8 bits read at address 2 and its top 3 bits read at address 3 bits 2:0. SOF status (address 3 bit 4) sets on the strobe when the SOF mask (address 3 bit 5, read/write) is 0. Writing 1 to bit 4 clears the status, and a same-cycle strobe wins over the clear.
- R9: Reserved bits read 0 and writes to them have no effect. Writes to address 2 and to address 3 bits 2:0 also have no effect.
- R10: The interrupt output is high one clock after any request bit or the SOF status is high, and low one clock after all of them are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_in_done | input | 1 | Bulk IN packet complete flag |
| ev_out_rdy | input | 1 | Bulk OUT packet ready flag |
| ev_iso_in_done | input | 1 | Isochronous IN packet complete flag |
| ev_iso_in_urun | input | 1 | Isochronous IN transmit underrun flag |
| ev_iso_out_rdy | input | 1 | Isochronous OUT packet ready flag |
| ev_iso_out_ovf | input | 1 | Isochronous OUT receive overflow flag |
| iso_err_stb | input | 1 | Isochronous OUT error strobe |
| sof_stb | input | 1 | SOF packet received strobe |
| sof_frame | input | FRAME_W | Frame number of the received SOF |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (read and write) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, an 11-bit frame number split 8/3, and a 2-bit address. With these values every field position in the map is fixed, so directed reads can be checked against literal values. Directed sequences cover the following cases:
- masking, including a mask change taking effect one clock later;
- each set source of every endpoint;
- a request re-setting from a still-pending isochronous error;
- the set-over-clear race on all three write-1-to-clear fields;
- writes to reserved and read-only bits.

A long randomized run then compares every read address and the interrupt line against a behavioural model on each clock.

// File: rtl/usb_ep_irq_regs.sv
module usb_ep_irq_regs #(
  parameter int DATA_W     = 8,
  parameter int FRAME_W    = 11,
  parameter int FRAME_LO_W = 8,
  parameter int ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_in_done,
  input  logic              ev_out_rdy,
  input  logic              ev_iso_in_done,
  input  logic              ev_iso_in_urun,
  input  logic              ev_iso_out_rdy,
  input  logic              ev_iso_out_ovf,
  input  logic              iso_err_stb,
  input  logic              sof_stb,
  input  logic [FRAME_W-1:0] sof_frame,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int NUM_EP     = 4;
  localparam int FRAME_HI_W = FRAME_W - FRAME_LO_W;
  localparam int ERR_B      = FRAME_HI_W;
  localparam int SOF_B      = ERR_B + 1;
  localparam int SMSK_B     = SOF_B + 1;

  logic [NUM_EP-1:0]  req_q, mask_q, ev_set, req_clr;
  logic [FRAME_W-1:0] frame_q;
  logic               err_q, sof_q, sof_mask_q, irq_q;
  logic               sel_req, sel_mask, sel_fnh;

  assign sel_req  = bus_wr && (bus_addr == ADDR_W'(0));
  assign sel_mask = bus_wr && (bus_addr == ADDR_W'(1));
  assign sel_fnh  = bus_wr && (bus_addr == ADDR_W'(3));

  assign ev_set[0] = ~mask_q[0] & ev_in_done;
  assign ev_set[1] = ~mask_q[1] & ev_out_rdy;
  assign ev_set[2] = ~mask_q[2] & (ev_iso_in_done | ev_iso_in_urun);
  assign ev_set[3] = ~mask_q[3] & (ev_iso_out_rdy | ev_iso_out_ovf | err_q);

  assign req_clr = sel_req ? bus_wdata[NUM_EP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= '0;
      mask_q     <= '1;
      frame_q    <= '0;
      err_q      <= 1'b0;
      sof_q      <= 1'b0;
      sof_mask_q <= 1'b1;
      irq_q      <= 1'b0;
    end else begin
      req_q <= (req_q & ~req_clr) | ev_set;
      err_q <= (err_q & ~(sel_fnh & bus_wdata[ERR_B])) | iso_err_stb;
      sof_q <= (sof_q & ~(sel_fnh & bus_wdata[SOF_B])) | (sof_stb & ~sof_mask_q);
      irq_q <= (|req_q) | sof_q;
      if (sel_mask) mask_q <= bus_wdata[NUM_EP-1:0];
      if (sel_fnh)  sof_mask_q <= bus_wdata[SMSK_B];
      if (sof_stb)  frame_q <= sof_frame;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(0): bus_rdata[NUM_EP-1:0] = req_q;
      ADDR_W'(1): bus_rdata[NUM_EP-1:0] = mask_q;
      ADDR_W'(2): bus_rdata[FRAME_LO_W-1:0] = frame_q[FRAME_LO_W-1:0];
      ADDR_W'(3): begin
        bus_rdata[FRAME_HI_W-1:0] = frame_q[FRAME_W-1:FRAME_LO_W];
        bus_rdata[ERR_B]  = err_q;
        bus_rdata[SOF_B]  = sof_q;
        bus_rdata[SMSK_B] = sof_mask_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq = irq_q;
endmodule

// File: rtl/usb_ep_irq_regs_chk.sv
module usb_ep_irq_regs_chk #(
  parameter int FRAME_W = 11,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_in_done,
  input logic               ev_out_rdy,
  input logic               ev_iso_in_done,
  input logic               ev_iso_in_urun,
  input logic               ev_iso_out_rdy,
  input logic               ev_iso_out_ovf,
  input logic               iso_err_stb,
  input logic               sof_stb,
  input logic [FRAME_W-1:0] sof_frame,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               irq,
  input logic [3:0]         req_q,
  input logic [3:0]         mask_q,
  input logic [FRAME_W-1:0] frame_q,
  input logic               err_q,
  input logic               sof_q,
  input logic               sof_mask_q
);
  p_masked_stays_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & ~req_q) != 4'd0) |=> ((req_q & $past(mask_q & ~req_q)) == 4'd0));

  p_bulk_in_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[0] && ev_in_done) |=> req_q[0]);

  p_bulk_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[1] && ev_out_rdy) |=> req_q[1]);

  p_iso_in_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[2] && (ev_iso_in_done || ev_iso_in_urun)) |=> req_q[2]);

  p_iso_out_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[3] && (ev_iso_out_rdy || ev_iso_out_ovf || err_q)) |=> req_q[3]);

  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[0] && !(!mask_q[0] && ev_in_done))
    |=> !req_q[0]);

  p_zero_write_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[1] && !(bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[1])) |=> req_q[1]);

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iso_err_stb |=> err_q);

  p_frame_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_stb |=> (frame_q == $past(sof_frame)));

  p_sof_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_stb && !sof_mask_q) |=> sof_q);

  p_irq_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q != 4'd0) || sof_q) |=> irq);

  p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q == 4'd0) && !sof_q) |=> !irq);
endmodule

bind usb_ep_irq_regs usb_ep_irq_regs_chk #(
  .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_in_done(ev_in_done), .ev_out_rdy(ev_out_rdy),
  .ev_iso_in_done(ev_iso_in_done), .ev_iso_in_urun(ev_iso_in_urun),
  .ev_iso_out_rdy(ev_iso_out_rdy), .ev_iso_out_ovf(ev_iso_out_ovf),
  .iso_err_stb(iso_err_stb), .sof_stb(sof_stb), .sof_frame(sof_frame),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
  .req_q(req_q), .mask_q(mask_q), .frame_q(frame_q), .err_q(err_q),
  .sof_q(sof_q), .sof_mask_q(sof_mask_q)
);

// File: tb/test_usb_ep_irq_regs.sv
`timescale 1ns/1ps
module test_usb_ep_irq_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ev_in_done = 0, ev_out_rdy = 0, ev_iso_in_done = 0, ev_iso_in_urun = 0;
  logic        ev_iso_out_rdy = 0, ev_iso_out_ovf = 0, iso_err_stb = 0, sof_stb = 0;
  logic [10:0] sof_frame = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        irq;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_ep_irq_regs i_usb_ep_irq_regs (
    .clk(clk), .rst_n(rst_n),
    .ev_in_done(ev_in_done), .ev_out_rdy(ev_out_rdy),
    .ev_iso_in_done(ev_iso_in_done), .ev_iso_in_urun(ev_iso_in_urun),
    .ev_iso_out_rdy(ev_iso_out_rdy), .ev_iso_out_ovf(ev_iso_out_ovf),
    .iso_err_stb(iso_err_stb), .sof_stb(sof_stb), .sof_frame(sof_frame),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  bit [3:0]  m_req = 0, m_mask = 4'hF, m_set, m_clr;
  bit [10:0] m_frame = 0;
  bit        m_err = 0, m_sof = 0, m_smask = 1, m_irq = 0;
  bit        w0, w1, w3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_mask = 4'hF; m_frame = 0;
      m_err = 0; m_sof = 0; m_smask = 1; m_irq = 0;
    end else begin
      w0 = bus_wr && bus_addr == 2'd0;
      w1 = bus_wr && bus_addr == 2'd1;
      w3 = bus_wr && bus_addr == 2'd3;
      m_irq = (m_req != 0) || m_sof;
      m_set[0] = !m_mask[0] && ev_in_done;
      m_set[1] = !m_mask[1] && ev_out_rdy;
      m_set[2] = !m_mask[2] && (ev_iso_in_done || ev_iso_in_urun);
      m_set[3] = !m_mask[3] && (ev_iso_out_rdy || ev_iso_out_ovf || m_err);
      m_clr = w0 ? bus_wdata[3:0] : 4'd0;
      m_req = (m_req & ~m_clr) | m_set;
      m_err = (m_err && !(w3 && bus_wdata[3])) || iso_err_stb;
      m_sof = (m_sof && !(w3 && bus_wdata[4])) || (sof_stb && !m_smask);
      if (w1) m_mask = bus_wdata[3:0];
      if (w3) m_smask = bus_wdata[5];
      if (sof_stb) m_frame = sof_frame;
    end
  end

  function automatic logic [7:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0: m_rd = {4'd0, m_req};
      2'd1: m_rd = {4'd0, m_mask};
      2'd2: m_rd = m_frame[7:0];
      default: m_rd = {2'd0, m_smask, m_sof, m_err, m_frame[10:8]};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    string t;
    @(negedge clk);
    if (rst_n) begin
      case (bus_addr)
        2'd0: t = "R6";
        2'd1: t = "R2";
        default: t = "R8";
      endcase
      chk(t, bus_rdata, m_rd(bus_addr));
      chk("R10", {7'd0, irq}, {7'd0, m_irq});
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1 reset state
    rd(0, 8'h00, "R1"); rd(1, 8'h0F, "R1"); rd(3, 8'h20, "R1"); rd(2, 8'h00, "R1");
    chk("R1", {7'd0, irq}, 8'h00);

    // R2 masked event does not set, then unmasked sets
    ev_in_done = 1; tick(); tick(); ev_in_done = 0;
    rd(0, 8'h00, "R2");
    wr(1, 8'h0E); rd(1, 8'h0E, "R2");
    ev_in_done = 1; tick(); ev_in_done = 0;
    rd(0, 8'h01, "R2");
    chk("R10", {7'd0, irq}, 8'h00);
    tick(); chk("R10", {7'd0, irq}, 8'h01);
    wr(0, 8'h01); rd(0, 8'h00, "R6");
    chk("R10", {7'd0, irq}, 8'h01);
    tick(); chk("R10", {7'd0, irq}, 8'h00);

    // R3 bulk OUT, zero write keeps (R6)
    wr(1, 8'h00);
    ev_out_rdy = 1; tick(); ev_out_rdy = 0;
    rd(0, 8'h02, "R3");
    wr(0, 8'h00); rd(0, 8'h02, "R6");
    wr(0, 8'h02); rd(0, 8'h00, "R6");

    // R4 isochronous IN, both sources
    ev_iso_in_urun = 1; tick(); ev_iso_in_urun = 0;
    rd(0, 8'h04, "R4");
    wr(0, 8'h04); rd(0, 8'h00, "R4");
    ev_iso_in_done = 1; tick(); ev_iso_in_done = 0;
    rd(0, 8'h04, "R4");
    wr(0, 8'h04); rd(0, 8'h00, "R4");

    // R5 isochronous OUT: overflow, ready, stored error
    ev_iso_out_ovf = 1; tick(); ev_iso_out_ovf = 0;
    rd(0, 8'h08, "R5"); wr(0, 8'h08); rd(0, 8'h00, "R5");
    ev_iso_out_rdy = 1; tick(); ev_iso_out_rdy = 0;
    rd(0, 8'h08, "R5"); wr(0, 8'h08); rd(0, 8'h00, "R5");
    iso_err_stb = 1; tick(); iso_err_stb = 0;
    rd(3, 8'h28, "R7"); rd(0, 8'h00, "R5");
    tick(); rd(0, 8'h08, "R5");
    wr(3, 8'h28); rd(3, 8'h20, "R7");
    wr(0, 8'h08); rd(0, 8'h00, "R5");

    // R6 set wins over same-cycle clear
    ev_in_done = 1; tick();
    wr(0, 8'h01); ev_in_done = 0;
    rd(0, 8'h01, "R6");
    wr(0, 8'h01); rd(0, 8'h00, "R6");

    // R7 set wins over same-cycle clear
    iso_err_stb = 1; wr(3, 8'h28); iso_err_stb = 0;
    rd(3, 8'h28, "R7");
    wr(3, 8'h28); wr(0, 8'h08); rd(0, 8'h00, "R7");

    // R8 frame capture and SOF status
    sof_frame = 11'h5A3; sof_stb = 1; tick(); sof_stb = 0;
    rd(2, 8'hA3, "R8"); rd(3, 8'h25, "R8");
    wr(3, 8'h00); rd(3, 8'h05, "R8");
    sof_frame = 11'h2FF; sof_stb = 1; tick(); sof_stb = 0;
    rd(3, 8'h12, "R8"); rd(2, 8'hFF, "R8");
    tick(); chk("R10", {7'd0, irq}, 8'h01);
    wr(3, 8'h10); rd(3, 8'h02, "R8");
    sof_stb = 1; wr(3, 8'h10); sof_stb = 0;
    rd(3, 8'h12, "R8");
    wr(3, 8'h10); rd(3, 8'h02, "R8");

    // R9 reserved and read-only bits
    wr(2, 8'h00); rd(2, 8'hFF, "R9");
    wr(3, 8'hC7); rd(3, 8'h02, "R9");
    wr(0, 8'hF0); rd(0, 8'h00, "R9");
    wr(1, 8'hF0); rd(1, 8'h00, "R9");

    // randomized run against the model
    for (int i = 0; i < 4000; i++) begin
      ev_in_done     = ($urandom % 4) == 0;
      ev_out_rdy     = ($urandom % 4) == 0;
      ev_iso_in_done = ($urandom % 6) == 0;
      ev_iso_in_urun = ($urandom % 6) == 0;
      ev_iso_out_rdy = ($urandom % 6) == 0;
      ev_iso_out_ovf = ($urandom % 6) == 0;
      iso_err_stb    = ($urandom % 10) == 0;
      sof_stb        = ($urandom % 8) == 0;
      sof_frame      = 11'($urandom);
      bus_wr         = ($urandom % 3) == 0;
      bus_addr       = 2'($urandom);
      bus_wdata      = 8'($urandom);
      tick();
    end
    bus_wr = 0;
    tick();

    done = 1;
    summary();
    $finish;
  end
endmodule